// File: doc/BRIEF.md
# Master Clock Source Selector and Divider

This block derives a master clock and a processor clock from one of three source clocks: a slow clock, a main clock and a PLL clock. All clocks are modelled as single-cycle enable strobes in one fast reference domain. A source strobe marks one period of that source, and each output strobe marks one period of the derived clock. A configuration write carries a source code, a power-of-two prescaler code, a master divider code and a PLL half-rate bit. The processor strobe is the prescaler output. The master strobe is the processor strobe divided once more.

A ready flag reports when the derived clocks may be used. A change of source or prescaler drops the flag. The switch to a new source is glitch-free: the old source is gated off, the new source is enabled only after two of its own strobes, and the counters restart, so that no short period reaches the outputs. The flag rises again once one full master period has been produced. A write that changes both fields is applied in two steps: the prescaler first, then the source. When the PLL is the programmed source and its lock input drops, the block runs from the main clock on its own and keeps the flag low. It returns to the PLL once lock comes back.

Top module: `mclk_gen`

## Requirements
- R1: After reset the ready flag is 1, the active source is the slow clock (code 0), the prescaler and master divider codes are 0 and the half-rate bit is 0, so a master strobe follows every slow strobe.
- R2: Source code 0 selects the slow clock, 1 the main clock, 2 the PLL clock, and code 3 behaves as 2; `active_src` reports the source currently running, with the same encoding.
- R3: The prescaler divides the selected source by 2^code for codes 0 to 6; code 7 divides by 1.
- R4: `pck_tick` is the prescaler output. Master divider codes 0, 1, 2 and 3 give a `mck_tick` on every 1st, 2nd, 4th and 3rd processor strobe respectively, and every master strobe coincides with a processor strobe.
- R5: A half-rate bit of 1 halves the PLL strobe rate before source selection, and 0 passes it unchanged.
- R6: A write that changes the prescaler code or the source code makes `mck_ready` 0 in the cycle after the write. The flag returns to 1 only after one full, unshortened master period from the new setting.
- R7: While the programmed source is the PLL and `pll_locked` is 0, `mck_ready` is 0 and `active_src` falls back to the main clock (1). When lock returns, the block switches back to the PLL and sets the flag again.
- R8: A write that changes both prescaler and source applies the prescaler first. The active source stays the old one while the new prescaler settles, and `mck_ready` rises only once `active_src` equals the new source.
- R9: During a source switch, no output strobe is produced until two strobes of the new source have been seen. Every processor strobe coincides with a strobe of the active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Source code (0 slow, 1 main, 2/3 PLL) |
| cfg_pres | input | 3 | Prescaler code |
| cfg_mdiv | input | 2 | Master divider code |
| cfg_pll_half | input | 1 | PLL half-rate bit |
| slow_tick | input | 1 | Slow clock period strobe |
| main_tick | input | 1 | Main clock period strobe |
| pll_tick | input | 1 | PLL clock period strobe |
| pll_locked | input | 1 | PLL lock indication |
| pck_tick | output | 1 | Processor clock strobe |
| mck_tick | output | 1 | Master clock strobe |
| mck_ready | output | 1 | Derived clocks ready |
| active_src | output | 2 | Source currently driving the outputs |

## Verification
The hardest condition to reach is the two-step update. The prescaler must still be settling on the old source while a source change waits behind it, and the lock input can drop in the middle of either step. The bench reaches the first case with a directed write that changes both fields while the slow source is running. The slow source is long enough that the old source is still visible several cycles after the write. The bench reaches the second case by dropping lock while the PLL is selected and then restoring it. Random configurations then measure the master strobe spacing against a period computed from the source, prescaler, half-rate and divider codes.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
    localparam int PRES_W = 3;
    localparam int PCNT_W = 7;
    localparam int MDIV_W = 2;
    localparam int NSRC   = 3;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_PLL  = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SYNC   = 2'd1,
        ST_SETTLE = 2'd2
    } ctrl_st_e;

    function automatic src_e norm_src(input logic [1:0] code);
        return (code == 2'd3) ? SRC_PLL : src_e'(code);
    endfunction

    function automatic logic [PCNT_W-1:0] pres_ratio(input logic [PRES_W-1:0] code);
        return (code == PRES_W'(7)) ? PCNT_W'(1) : (PCNT_W'(1) << code);
    endfunction

    function automatic logic [2:0] mdiv_ratio(input logic [MDIV_W-1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd3;
        endcase
    endfunction
endpackage

// File: rtl/mclk_half.sv
module mclk_half (
    input  logic clk,
    input  logic rst,
    input  logic half_en,
    input  logic tick_in,
    output logic tick_out
);
    logic phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= 1'b0;
        else if (tick_in)
            phase <= ~phase;
    end

    assign tick_out = tick_in && (!half_en || phase);
endmodule

// File: rtl/mclk_prescale.sv
module mclk_prescale
    import mclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              tick_in,
    input  logic [PRES_W-1:0] code,
    output logic              tick_out
);
    logic [PCNT_W-1:0] cnt;
    logic [PCNT_W-1:0] last;

    assign last     = pres_ratio(code) - PCNT_W'(1);
    assign tick_out = tick_in && !restart && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick_in)
            cnt <= (cnt == last) ? '0 : cnt + PCNT_W'(1);
    end
endmodule

// File: rtl/mclk_mdiv.sv
module mclk_mdiv
    import mclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              tick_in,
    input  logic [MDIV_W-1:0] code,
    output logic              tick_out
);
    logic [1:0] cnt;
    logic [1:0] last;

    assign last     = 2'(mdiv_ratio(code) - 3'd1);
    assign tick_out = tick_in && !restart && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick_in)
            cnt <= (cnt == last) ? 2'd0 : cnt + 2'd1;
    end
endmodule

// File: rtl/mclk_ctrl.sv
module mclk_ctrl
    import mclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  src_e              cfg_src,
    input  logic [PRES_W-1:0] cfg_pres,
    input  logic [NSRC-1:0]   src_ticks,
    input  logic              pll_locked,
    input  logic              mck_tick,
    output logic [PRES_W-1:0] pres_cur,
    output src_e              sel_cur,
    output src_e              active,
    output logic              run_en,
    output logic              restart,
    output logic              ready
);
    ctrl_st_e   state;
    src_e       pend_src;
    src_e       sync_tgt;
    src_e       target;
    logic       sync_cnt;
    logic       pres_wr;
    logic       sync_done;
    logic       pll_down;

    assign pll_down  = (sel_cur == SRC_PLL) && !pll_locked;
    assign target    = pll_down ? SRC_MAIN : sel_cur;
    assign pres_wr   = cfg_wr && (cfg_pres != pres_cur);
    assign sync_done = (state == ST_SYNC) && (target == sync_tgt)
                       && src_ticks[target] && sync_cnt;
    assign restart   = pres_wr || sync_done;
    assign run_en    = (state != ST_SYNC);
    assign ready     = (state == ST_RUN) && (target == active)
                       && (sel_cur == pend_src) && !pll_down;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            pend_src <= SRC_SLOW;
            sel_cur  <= SRC_SLOW;
            active   <= SRC_SLOW;
            sync_tgt <= SRC_SLOW;
            sync_cnt <= 1'b0;
            pres_cur <= '0;
        end else begin
            if (cfg_wr)
                pend_src <= cfg_src;
            if (pres_wr) begin
                pres_cur <= cfg_pres;
                state    <= ST_SETTLE;
            end else begin
                case (state)
                    ST_RUN: begin
                        if (target != active) begin
                            state    <= ST_SYNC;
                            sync_tgt <= target;
                            sync_cnt <= 1'b0;
                        end else if (sel_cur != pend_src) begin
                            sel_cur <= pend_src;
                        end
                    end
                    ST_SYNC: begin
                        if (target != sync_tgt) begin
                            sync_tgt <= target;
                            sync_cnt <= 1'b0;
                        end else if (src_ticks[target]) begin
                            if (sync_cnt) begin
                                active <= target;
                                state  <= ST_SETTLE;
                            end else begin
                                sync_cnt <= 1'b1;
                            end
                        end
                    end
                    default: begin
                        if (target != active) begin
                            state    <= ST_SYNC;
                            sync_tgt <= target;
                            sync_cnt <= 1'b0;
                        end else if (mck_tick) begin
                            state <= ST_RUN;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
    import mclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_src,
    input  logic [2:0] cfg_pres,
    input  logic [1:0] cfg_mdiv,
    input  logic       cfg_pll_half,
    input  logic       slow_tick,
    input  logic       main_tick,
    input  logic       pll_tick,
    input  logic       pll_locked,
    output logic       pck_tick,
    output logic       mck_tick,
    output logic       mck_ready,
    output logic [1:0] active_src
);
    logic [MDIV_W-1:0] mdiv_q;
    logic              half_q;
    logic              pll_eff;
    logic [NSRC-1:0]   src_ticks;
    logic [PRES_W-1:0] pres_cur;
    src_e              sel_cur;
    src_e              act;
    logic              run_en;
    logic              restart;
    logic              mdiv_wr;
    logic              gated_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdiv_q <= '0;
            half_q <= 1'b0;
        end else if (cfg_wr) begin
            mdiv_q <= cfg_mdiv;
            half_q <= cfg_pll_half;
        end
    end

    assign mdiv_wr = cfg_wr && (cfg_mdiv != mdiv_q);

    mclk_half u_half (
        .clk      (clk),
        .rst      (rst),
        .half_en  (half_q),
        .tick_in  (pll_tick),
        .tick_out (pll_eff)
    );

    assign src_ticks = {pll_eff, main_tick, slow_tick};

    mclk_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_src    (norm_src(cfg_src)),
        .cfg_pres   (cfg_pres),
        .src_ticks  (src_ticks),
        .pll_locked (pll_locked),
        .mck_tick   (mck_tick),
        .pres_cur   (pres_cur),
        .sel_cur    (sel_cur),
        .active     (act),
        .run_en     (run_en),
        .restart    (restart),
        .ready      (mck_ready)
    );

    assign gated_tick = run_en && src_ticks[act];

    mclk_prescale u_pres (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .tick_in  (gated_tick),
        .code     (pres_cur),
        .tick_out (pck_tick)
    );

    mclk_mdiv u_mdiv (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart || mdiv_wr),
        .tick_in  (pck_tick),
        .code     (mdiv_q),
        .tick_out (mck_tick)
    );

    assign active_src = act;
endmodule

// File: rtl/mclk_chk.sv
module mclk_chk
    import mclk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [2:0]        cfg_pres,
    input logic              slow_tick,
    input logic              main_tick,
    input logic              pll_locked,
    input logic              pck_tick,
    input logic              mck_tick,
    input logic              mck_ready,
    input logic [1:0]        active_src,
    input logic [PRES_W-1:0] pres_cur,
    input logic [1:0]        sel_cur,
    input logic [MDIV_W-1:0] mdiv_q
);
    // R4
    mck_in_pck_chk: assert property (@(posedge clk) disable iff (rst)
        mck_tick |-> pck_tick);

    // R4
    mdiv_one_chk: assert property (@(posedge clk) disable iff (rst)
        (mdiv_q == 2'd0) |-> (mck_tick == pck_tick));

    // R6
    pres_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && (cfg_pres != pres_cur)) |=> !mck_ready);

    // R7
    unlock_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((sel_cur == 2'd2) && !pll_locked) |-> !mck_ready);

    // R9
    slow_align_chk: assert property (@(posedge clk) disable iff (rst)
        (pck_tick && (active_src == 2'd0)) |-> slow_tick);

    // R9
    main_align_chk: assert property (@(posedge clk) disable iff (rst)
        (pck_tick && (active_src == 2'd1)) |-> main_tick);
endmodule

bind mclk_gen mclk_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_pres   (cfg_pres),
    .slow_tick  (slow_tick),
    .main_tick  (main_tick),
    .pll_locked (pll_locked),
    .pck_tick   (pck_tick),
    .mck_tick   (mck_tick),
    .mck_ready  (mck_ready),
    .active_src (active_src),
    .pres_cur   (pres_cur),
    .sel_cur    (sel_cur),
    .mdiv_q     (mdiv_q)
);

// File: tb/test_mclk_gen.sv
module test_mclk_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_src = 2'd0;
    logic [2:0] cfg_pres = 3'd0;
    logic [1:0] cfg_mdiv = 2'd0;
    logic       cfg_pll_half = 1'b0;
    logic       slow_tick = 1'b0;
    logic       main_tick = 1'b0;
    logic       pll_tick = 1'b1;
    logic       pll_locked = 1'b1;
    logic       pck_tick, mck_tick, mck_ready;
    logic [1:0] active_src;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int sc = 0;
    int mc = 0;

    mclk_gen i_mclk_gen (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_src(cfg_src),
        .cfg_pres(cfg_pres), .cfg_mdiv(cfg_mdiv), .cfg_pll_half(cfg_pll_half),
        .slow_tick(slow_tick), .main_tick(main_tick), .pll_tick(pll_tick),
        .pll_locked(pll_locked), .pck_tick(pck_tick), .mck_tick(mck_tick),
        .mck_ready(mck_ready), .active_src(active_src)
    );

    always #4 clk = ~clk;

    // source strobes: slow every 11 cycles, main every 3, PLL every cycle
    initial forever begin
        @(negedge clk);
        sc = (sc == 10) ? 0 : sc + 1;
        mc = (mc == 2) ? 0 : mc + 1;
        slow_tick = (sc == 0);
        main_tick = (mc == 0);
    end

    initial forever begin
        @(posedge clk);
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected <190000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk); #2;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_gap(int src, int pres, int mdiv, int half);
        int per, p, m;
        per = (src == 0) ? 11 : (src == 1) ? 3 : (half ? 2 : 1);
        p = (pres == 7) ? 1 : (1 << pres);
        m = (mdiv == 0) ? 1 : (mdiv == 1) ? 2 : (mdiv == 2) ? 4 : 3;
        return per * p * m;
    endfunction

    task automatic write_cfg(input int src, input int pres, input int mdiv, input int half);
        step();
        cfg_src = 2'(src); cfg_pres = 3'(pres); cfg_mdiv = 2'(mdiv);
        cfg_pll_half = 1'(half); cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic wait_ready(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (mck_ready) begin ok = 1'b1; break; end
            step();
        end
    endtask

    task automatic measure(output int gap);
        int t0;
        gap = -1;
        t0 = -1;
        for (int i = 0; i < 20000; i++) begin
            step();
            if (mck_tick) begin
                if (t0 < 0) t0 = i;
                else begin gap = i - t0; break; end
            end
        end
    endtask

    initial begin
        bit ok;
        int g;
        void'($urandom(32'd1234));
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        check(mck_ready == 1'b1, "R1 ready", int'(mck_ready), 1);
        check(active_src == 2'd0, "R1 src", int'(active_src), 0);
        measure(g);
        check(g == 11, "R1 gap", g, 11);

        // R6 prescaler change drops ready next cycle
        write_cfg(0, 2, 0, 0);
        check(mck_ready == 1'b0, "R6 pres drop", int'(mck_ready), 0);
        wait_ready(ok);
        check(ok, "R6 ready back", int'(ok), 1);
        measure(g);
        check(g == exp_gap(0, 2, 0, 0), "R3 slow/4", g, exp_gap(0, 2, 0, 0));

        // R6 source only change
        write_cfg(1, 2, 0, 0);
        check(mck_ready == 1'b0, "R6 src drop", int'(mck_ready), 0);
        wait_ready(ok);
        check(active_src == 2'd1, "R2 main", int'(active_src), 1);
        measure(g);
        check(g == exp_gap(1, 2, 0, 0), "R6 first full period", g, exp_gap(1, 2, 0, 0));

        // R4 divide by 3
        write_cfg(1, 0, 3, 0);
        wait_ready(ok);
        measure(g);
        check(g == 9, "R4 div3", g, 9);

        // R3 reserved prescaler code
        write_cfg(1, 7, 1, 0);
        wait_ready(ok);
        measure(g);
        check(g == 6, "R3 code7", g, 6);

        // R5 PLL half rate, R2 code 3 maps to PLL
        write_cfg(3, 0, 0, 1);
        wait_ready(ok);
        check(active_src == 2'd2, "R2 code3", int'(active_src), 2);
        measure(g);
        check(g == 2, "R5 half", g, 2);
        write_cfg(2, 0, 0, 0);
        wait_ready(ok);
        measure(g);
        check(g == 1, "R5 full", g, 1);

        // R7 unlock fallback
        write_cfg(2, 1, 2, 0);
        wait_ready(ok);
        step();
        pll_locked = 1'b0;
        step();
        check(mck_ready == 1'b0, "R7 unlock low", int'(mck_ready), 0);
        repeat (200) step();
        check(active_src == 2'd1, "R7 fallback", int'(active_src), 1);
        check(mck_ready == 1'b0, "R7 still low", int'(mck_ready), 0);
        measure(g);
        check(g == exp_gap(1, 1, 2, 0), "R7 main gap", g, exp_gap(1, 1, 2, 0));
        pll_locked = 1'b1;
        wait_ready(ok);
        check(ok && active_src == 2'd2, "R7 relock", int'(active_src), 2);
        measure(g);
        check(g == exp_gap(2, 1, 2, 0), "R7 pll gap", g, exp_gap(2, 1, 2, 0));

        // R8 combined change: prescaler first, then source
        write_cfg(0, 0, 0, 0);
        wait_ready(ok);
        write_cfg(1, 3, 0, 0);
        step(); step();
        check(active_src == 2'd0, "R8 old src kept", int'(active_src), 0);
        check(mck_ready == 1'b0, "R8 low", int'(mck_ready), 0);
        wait_ready(ok);
        check(active_src == 2'd1, "R8 new src at ready", int'(active_src), 1);
        measure(g);
        check(g == exp_gap(1, 3, 0, 0), "R8 gap", g, exp_gap(1, 3, 0, 0));

        // R9 and R2-R4 random configurations
        for (int k = 0; k < 16; k++) begin
            int s, p, m, h;
            s = int'($urandom % 3); p = int'($urandom % 5);
            m = int'($urandom % 4); h = int'($urandom % 2);
            write_cfg(s, p, m, h);
            wait_ready(ok);
            check(ok && active_src == 2'(s), "R9 random src", int'(active_src), s);
            measure(g);
            check(g == exp_gap(s, p, m, h), "R9 random gap", g, exp_gap(s, p, m, h));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule